// File: doc/BRIEF.md
# System-Management-Aware Interrupt Request Arbiter

This block keeps the pending interrupt requests of a small processor core and decides, at each instruction boundary, whether the core should enter system-management mode (SMM) or take a maskable hardware interrupt. Request sources raise bits in a pending vector through one-cycle set pulses, and the owners of those bits retire them through one-cycle clear pulses. The block also holds the core's SMM-mode flag. The flag is raised when the block accepts a system-management interrupt (SMI), and it is lowered when the core reports that it has left SMM.

The core raises a boundary strobe when an instruction completes. In that cycle the arbiter raises at most one grant strobe, combinationally.

- An SMI has priority over all other requests. It does not look at the interrupt-enable flag or the interrupt-shadow flag. It is held off only while the core is already in SMM.
- When the block accepts an SMI, it clears the SMI pending bit and sets the SMM flag together, on the clock edge that closes the grant cycle.
- A hardware interrupt is granted only when interrupts are enabled and no shadow is active. Its pending bit is left to its owner to clear.

Top module: `smi_irq_arbiter`

## Requirements
- R1: After a synchronous active-low reset, the pending vector is zero, the SMM flag is clear and no grant strobe is high.
- R2: A set pulse on any bit latches that bit into the pending vector on the next clock edge. The SMI request is bit 6 (mask 0x40) and the hardware interrupt request is bit 1 (mask 0x02).
- R3: In a cycle without the boundary strobe, neither grant strobe is raised, whatever is pending.
- R4: At a boundary, a pending SMI is granted when the SMM flag is clear, regardless of the interrupt-enable and shadow flags.
- R5: In the SMI grant cycle, the clear output carries mask 0x40. On the following edge the SMI pending bit drops, unless it is set again in that same cycle, and the SMM flag rises.
- R6: When an SMI and a hardware interrupt are both eligible at the same boundary, only the SMI is granted.
- R7: A pending hardware interrupt is granted at a boundary only when the enable flag is 1 and the shadow flag is 0. Granting it leaves its pending bit unchanged.
- R8: An SMI that is pending while the SMM flag is set is not granted and stays pending. It is granted at the first boundary after the flag clears.
- R9: At most one grant strobe is high in any cycle.
- R10: A clear pulse drops the selected pending bits on the next edge. A set and a clear of the same bit in the same cycle leave the bit set.
- R11: The SMM exit pulse clears the SMM flag on the next edge. A boundary in the same cycle as the exit pulse still sees the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set_i | input | NREQ | One-cycle set pulses, one per request bit |
| req_clr_i | input | NREQ | One-cycle clear pulses, one per request bit |
| boundary_i | input | 1 | Instruction-boundary evaluation strobe |
| int_en_i | input | 1 | Maskable interrupt enable flag |
| int_shadow_i | input | 1 | Interrupt-inhibit shadow flag |
| smm_exit_i | input | 1 | Pulse that reports the core has left SMM |
| take_smi_o | output | 1 | Strobe: enter SMM now |
| take_irq_o | output | 1 | Strobe: take the hardware interrupt now |
| smi_clr_o | output | NREQ | Pending bit retired by the current SMI grant |
| pend_o | output | NREQ | Current pending request vector |
| smm_o | output | 1 | SMM-mode flag |

## Verification
The assertions check the following on every cycle:
- that the two grant strobes are mutually exclusive;
- that no grant is raised off a boundary;
- that hardware grants respect the enable and shadow flags;
- that no SMI is granted while in SMM;
- that an SMI grant is always followed by the SMM flag and a dropped SMI bit.

Only the bench scenarios can show the following:
- that an eligible request is actually granted, so no grant is missed;
- that a held-off SMI is granted after exit;
- that the SMI wins over an eligible hardware interrupt;
- the ordering of set against clear;
- the same-cycle exit-and-boundary case.

// File: rtl/smi_arb_pkg.sv
// Package: shared types for the SMI-aware interrupt arbiter.
// Assumes: at most one grant kind per evaluation.
package smi_arb_pkg;
    typedef enum logic [1:0] {
        GNT_NONE = 2'd0,
        GNT_SMI  = 2'd1,
        GNT_IRQ  = 2'd2
    } grant_e;
endpackage

// File: rtl/arb_pend_reg.sv
// Module: pending request register.
// Each bit is set by a set pulse and cleared by a clear pulse or an
// acknowledge pulse. A set wins over a clear in the same cycle.
// Assumes: synchronous active-low reset.
module arb_pend_reg #(
    parameter int NREQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] set_i,
    input  logic [NREQ-1:0] clr_i,
    input  logic [NREQ-1:0] ack_i,
    output logic [NREQ-1:0] pend_o
);
    logic [NREQ-1:0] pend_q;

    for (genvar b = 0; b < NREQ; b++) begin : g_bit
        // Purpose: hold one pending bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[b] <= 1'b0;
            else
                pend_q[b] <= set_i[b] | (pend_q[b] & ~clr_i[b] & ~ack_i[b]);
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/arb_decide.sv
// Module: combinational grant decision.
// An SMI wins when the core is outside SMM. A hardware interrupt is
// granted only when enabled and unshadowed. Nothing is granted off a boundary.
// Assumes: SMI_BIT != IRQ_BIT.
module arb_decide
    import smi_arb_pkg::*;
#(
    parameter int NREQ    = 8,
    parameter int SMI_BIT = 6,
    parameter int IRQ_BIT = 1
) (
    input  logic [NREQ-1:0] pend_i,
    input  logic            boundary_i,
    input  logic            int_en_i,
    input  logic            int_shadow_i,
    input  logic            smm_i,
    output grant_e          grant_o
);
    logic smi_ok;
    logic irq_ok;

    assign smi_ok = pend_i[SMI_BIT] & ~smm_i;
    assign irq_ok = pend_i[IRQ_BIT] & int_en_i & ~int_shadow_i;

    // Purpose: fixed priority, SMI first, then hardware interrupt.
    always_comb begin
        grant_o = GNT_NONE;
        if (boundary_i) begin
            if (smi_ok)
                grant_o = GNT_SMI;
            else if (irq_ok)
                grant_o = GNT_IRQ;
        end
    end
endmodule

// File: rtl/arb_smm_flag.sv
// Module: SMM-mode flag.
// Set on an SMI grant and cleared by the exit pulse.
// Assumes: a grant and an exit never coincide, because no SMI is
// granted while the flag is set.
module arb_smm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic exit_i,
    output logic smm_o
);
    logic smm_q;

    // Purpose: track whether the core is in SMM.
    always_ff @(posedge clk) begin
        if (!rst_n)
            smm_q <= 1'b0;
        else if (enter_i)
            smm_q <= 1'b1;
        else if (exit_i)
            smm_q <= 1'b0;
    end

    assign smm_o = smm_q;
endmodule

// File: rtl/smi_irq_arbiter.sv
// Module: top of the SMI-aware interrupt arbiter.
// Holds the pending vector and the SMM flag, and raises one grant strobe
// per instruction boundary.
// Assumes: the boundary strobe lasts one cycle per instruction.
module smi_irq_arbiter
    import smi_arb_pkg::*;
#(
    parameter int NREQ    = 8,
    parameter int SMI_BIT = 6,
    parameter int IRQ_BIT = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_set_i,
    input  logic [NREQ-1:0] req_clr_i,
    input  logic            boundary_i,
    input  logic            int_en_i,
    input  logic            int_shadow_i,
    input  logic            smm_exit_i,
    output logic            take_smi_o,
    output logic            take_irq_o,
    output logic [NREQ-1:0] smi_clr_o,
    output logic [NREQ-1:0] pend_o,
    output logic            smm_o
);
    localparam logic [NREQ-1:0] SMI_MASK = NREQ'(1) << SMI_BIT;

    grant_e          grant;
    logic [NREQ-1:0] pend;
    logic            smm;
    logic [NREQ-1:0] ack;

    assign ack = (grant == GNT_SMI) ? SMI_MASK : '0;

    arb_pend_reg #(.NREQ(NREQ)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_set_i),
        .clr_i  (req_clr_i),
        .ack_i  (ack),
        .pend_o (pend)
    );

    arb_decide #(.NREQ(NREQ), .SMI_BIT(SMI_BIT), .IRQ_BIT(IRQ_BIT)) u_dec (
        .pend_i       (pend),
        .boundary_i   (boundary_i),
        .int_en_i     (int_en_i),
        .int_shadow_i (int_shadow_i),
        .smm_i        (smm),
        .grant_o      (grant)
    );

    arb_smm_flag u_smm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enter_i (grant == GNT_SMI),
        .exit_i  (smm_exit_i),
        .smm_o   (smm)
    );

    assign take_smi_o = (grant == GNT_SMI);
    assign take_irq_o = (grant == GNT_IRQ);
    assign smi_clr_o  = ack;
    assign pend_o     = pend;
    assign smm_o      = smm;

    // R9: grants are exclusive
    p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_smi_o && take_irq_o));
    // R3: no grant off a boundary
    p_quiet_off_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_i |-> !(take_smi_o || take_irq_o));
    // R7: hardware grant respects enable and shadow
    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq_o |-> (int_en_i && !int_shadow_i));
    // R8: no SMI grant inside SMM
    p_smi_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smm_o |-> !take_smi_o);
    // R5: an SMI grant enters SMM and retires the bit unless it is set again
    p_smi_enters_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_smi_o |=> (smm_o && (!pend_o[SMI_BIT] || $past(req_set_i[SMI_BIT]))));
endmodule

// File: tb/sim_smi_irq_arbiter.sv
module sim_smi_irq_arbiter;
    localparam int N = 8;
    localparam logic [N-1:0] M_SMI = 8'h40;
    localparam logic [N-1:0] M_IRQ = 8'h02;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] set_v, clr_v;
    logic         bnd, ie, shd, ex;
    logic         tsmi, tirq, smm;
    logic [N-1:0] sclr, pend;
    int           checks = 0;
    int           errors = 0;

    always #10 clk = ~clk;

    smi_irq_arbiter #(.NREQ(N), .SMI_BIT(6), .IRQ_BIT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_set_i(set_v), .req_clr_i(clr_v),
        .boundary_i(bnd), .int_en_i(ie), .int_shadow_i(shd), .smm_exit_i(ex),
        .take_smi_o(tsmi), .take_irq_o(tirq), .smi_clr_o(sclr),
        .pend_o(pend), .smm_o(smm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive idle inputs at a falling edge.
    task automatic idle();
        @(negedge clk);
        set_v = '0; clr_v = '0; bnd = 0; ex = 0;
        #2;
    endtask

    task automatic t_reset();
        rst_n = 0; set_v = '0; clr_v = '0; bnd = 0; ie = 0; shd = 0; ex = 0;
        repeat (2) @(negedge clk);
        rst_n = 1; #2;
        chk("R1 pend", 32'(pend), 0);
        chk("R1 smm", 32'(smm), 0);
        chk("R1 grants", 32'({tsmi, tirq}), 0);
    endtask

    task automatic t_latch();
        @(negedge clk); set_v = M_SMI | M_IRQ; ie = 1; #2;
        idle();
        chk("R2 pend", 32'(pend), 32'h42);
        chk("R3 no grant", 32'({tsmi, tirq}), 0);
    endtask

    task automatic t_smi_wins();
        @(negedge clk); bnd = 1; ie = 1; shd = 0; #2;
        chk("R6 smi", 32'(tsmi), 1);
        chk("R6 irq", 32'(tirq), 0);
        chk("R5 clr", 32'(sclr), 32'h40);
        idle();
        chk("R5 pend", 32'(pend), 32'h02);
        chk("R5 smm", 32'(smm), 1);
    endtask

    task automatic t_irq_gate();
        @(negedge clk); bnd = 1; ie = 1; shd = 1; #2;
        chk("R7 shadow", 32'(tirq), 0);
        @(negedge clk); bnd = 1; ie = 0; shd = 0; #2;
        chk("R7 disabled", 32'(tirq), 0);
        @(negedge clk); bnd = 1; ie = 1; shd = 0; #2;
        chk("R7 taken", 32'(tirq), 1);
        idle();
        chk("R7 kept", 32'(pend), 32'h02);
    endtask

    task automatic t_smi_held();
        @(negedge clk); set_v = M_SMI; #2;
        @(negedge clk); set_v = '0; bnd = 1; ie = 0; #2;
        chk("R8 held", 32'(tsmi), 0);
        idle();
        chk("R8 pend", 32'(pend), 32'h42);
        @(negedge clk); ex = 1; bnd = 1; #2;
        chk("R11 same cycle", 32'(tsmi), 0);
        idle();
        chk("R11 exit", 32'(smm), 0);
        @(negedge clk); bnd = 1; ie = 0; shd = 1; #2;
        chk("R4 smi ignores flags", 32'(tsmi), 1);
        chk("R9 single", 32'({tsmi, tirq}), 32'h2);
        idle();
    endtask

    task automatic t_clear();
        @(negedge clk); clr_v = M_IRQ; #2;
        idle();
        chk("R10 clr", 32'(pend), 0);
        @(negedge clk); set_v = 8'h81; clr_v = 8'h81; #2;
        idle();
        chk("R10 set wins", 32'(pend), 32'h81);
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_latch();
        t_smi_wins();
        t_irq_gate();
        t_smi_held();
        t_clear();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule